// File: doc/BRIEF.md
# Buffered Configuration Port Transfer Engine

This block keeps one frame of configuration data in a local word buffer and moves a chosen number of bytes between that buffer and a 32-bit configuration port, in either direction. A host reaches the buffer and four control and status registers through a simple single-cycle register bus. The host first loads the byte count and the starting word, then writes the transfer direction, and that write starts the move.

In the configure direction the engine presents consecutive buffer words on a ready/valid output channel. In the readback direction it accepts words from a ready/valid input channel and stores them in consecutive buffer words. A status word combines a done flag, four bits that always read as one, and four flag inputs from the port. Any write to the status address abandons the running transfer and returns the engine to idle.

Top module: `cfgbuf_engine`

## Requirements
- R1: Buffer word n sits at bus byte address n*4, for addresses below 0x800. A bus read returns data on `bus_rdata` in the cycle after the read is presented.
- R2: The size register at 0x800 and the offset register at 0x804 hold any written value and read it back unchanged. Size is a byte count. Offset is a buffer word index.
- R3: A write to 0x808 starts a transfer. Bit 0 of the written value selects the direction: 0 means configure and 1 means readback. From the next cycle, status bit 0 reads 0 until the transfer completes.
- R4: A configure transfer presents floor(size/4) buffer words on `cp_wr_data`, starting at the offset word and going up by one word per accepted handshake.
- R5: A readback transfer stores floor(size/4) words taken from `cp_rd_data` at the offset word and the words above it. Buffer words outside that range do not change.
- R6: The status register is at 0x80C. Bit 0 is the done flag, bits 1 to 4 read 1, and bits 31 to 9 read 0. After reset the done flag reads 1.
- R7: Status bit 5 is `cp_abort_n`, bit 6 is `cp_rip`, bit 7 is `cp_aligned` and bit 8 is `cp_cfg_err`.
- R8: A write of any value to 0x80C stops a running transfer. From the next cycle done reads 1 and no further port handshakes occur.
- R9: A start write made while a transfer is running is ignored. The running transfer keeps its word count and its position.
- R10: If offset plus word count is larger than 512, the transfer stops after buffer word 511 and done reads 1. An offset of 512 or more moves no words.
- R11: A start with fewer than four bytes moves no words, and done still reads 1 on the next status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read |
| cp_wr_valid | output | 1 | Configure word is valid |
| cp_wr_ready | input | 1 | Port accepts the configure word |
| cp_wr_data | output | 32 | Configure word |
| cp_rd_valid | input | 1 | Port offers a readback word |
| cp_rd_ready | output | 1 | Engine accepts a readback word |
| cp_rd_data | input | 32 | Readback word |
| cp_abort_n | input | 1 | Port abort flag, active low |
| cp_rip | input | 1 | Port read-in-progress flag |
| cp_aligned | input | 1 | Port data-aligned flag |
| cp_cfg_err | input | 1 | Port configuration error flag |

## Verification
Some properties are checked on every cycle. While running, each handshake moves the address up by one and lowers the remaining count by one. Without a handshake, both values stay the same, even when a second start arrives. The buffer address plus the remaining count never passes the end of the buffer. A status write forces idle, with both port strobes low, on the next cycle. Every status read shows the fixed ones and zeros.

Only the bench scenarios can show the rest, because those checks need the full sequence. This covers the order and values of the words moved in each direction, and the floor of byte counts that are not a multiple of four. It also covers clamping at the top of the buffer, zero-length starts, and the fact that buffer words outside a readback range are left untouched.

// File: rtl/cfgbuf_pkg.sv
package cfgbuf_pkg;

   // register select taken from byte address bits [3:2] inside the register window
   typedef enum logic [1:0] {
      REG_SIZE   = 2'd0,
      REG_OFFSET = 2'd1,
      REG_DIR    = 2'd2,
      REG_STATUS = 2'd3
   } cfgbuf_reg_e;

   typedef enum logic {
      DIR_CONFIG   = 1'b0,
      DIR_READBACK = 1'b1
   } cfgbuf_dir_e;

   typedef enum logic {
      ENG_IDLE = 1'b0,
      ENG_RUN  = 1'b1
   } cfgbuf_state_e;

   localparam int STAT_DONE_BIT = 0;
   localparam int STAT_ONES_LO  = 1;
   localparam int STAT_ONES_HI  = 4;
   localparam int STAT_PORT_LO  = 5;

endpackage

// File: rtl/cfgbuf_ram.sv
module cfgbuf_ram #(
   parameter int WORDS  = 512,
   parameter int DATA_W = 32,
   localparam int AW    = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              h_we,
   input  logic [AW-1:0]     h_addr,
   input  logic [DATA_W-1:0] h_wdata,
   output logic [DATA_W-1:0] h_rdata,
   input  logic              e_we,
   input  logic [AW-1:0]     e_addr,
   input  logic [DATA_W-1:0] e_wdata,
   output logic [DATA_W-1:0] e_rdata
);

   logic [DATA_W-1:0] mem [WORDS];

   // engine writes win over host writes in the same cycle
   always_ff @(posedge clk) begin
      if (e_we)
         mem[e_addr] <= e_wdata;
      else if (h_we)
         mem[h_addr] <= h_wdata;
      h_rdata <= mem[h_addr];
   end

   assign e_rdata = mem[e_addr];

endmodule

// File: rtl/cfgbuf_seq.sv
module cfgbuf_seq
   import cfgbuf_pkg::*;
#(
   parameter int WORDS  = 512,
   parameter int DATA_W = 32,
   localparam int AW    = $clog2(WORDS),
   localparam int CNT_W = $clog2(WORDS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_dir,
   input  logic              abort_req,
   input  logic [DATA_W-1:0] size_bytes,
   input  logic [DATA_W-1:0] offset_words,
   input  logic              wr_ready,
   input  logic              rd_valid,
   input  logic [DATA_W-1:0] rd_data,
   output logic              done,
   output logic              wr_valid,
   output logic              rd_ready,
   output logic [AW-1:0]     mem_addr,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata
);

   cfgbuf_state_e     state;
   cfgbuf_dir_e       dir;
   logic [AW-1:0]     addr;
   logic [CNT_W-1:0]  remain;
   logic [DATA_W-1:0] req_words, room, eff;
   logic              run, fire;

   // clamp the requested count to the room left above the offset
   always_comb begin
      req_words = size_bytes >> 2;
      room      = (offset_words >= DATA_W'(WORDS)) ? '0 : DATA_W'(WORDS) - offset_words;
      eff       = (req_words < room) ? req_words : room;
   end

   assign run  = (state == ENG_RUN);
   assign fire = run && ((dir == DIR_READBACK) ? rd_valid : wr_ready);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ENG_IDLE;
         dir    <= DIR_CONFIG;
         addr   <= '0;
         remain <= '0;
      end else if (abort_req) begin
         state  <= ENG_IDLE;
         remain <= '0;
      end else if (!run) begin
         if (start && (eff != '0)) begin
            state  <= ENG_RUN;
            dir    <= cfgbuf_dir_e'(start_dir);
            addr   <= offset_words[AW-1:0];
            remain <= CNT_W'(eff);
         end
      end else if (fire) begin
         addr   <= addr + 1'b1;
         remain <= remain - 1'b1;
         if (remain == CNT_W'(1))
            state <= ENG_IDLE;
      end
   end

   assign done      = !run;
   assign wr_valid  = run && (dir == DIR_CONFIG);
   assign rd_ready  = run && (dir == DIR_READBACK);
   assign mem_addr  = addr;
   assign mem_we    = rd_ready && rd_valid;
   assign mem_wdata = rd_data;

   // R10: the remaining window never runs past the last buffer word
   p_window_in_buffer_r10: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (DATA_W'(addr) + DATA_W'(remain)) <= DATA_W'(WORDS));

   // R4 / R5: each handshake advances exactly one word
   p_step_one_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !abort_req && remain > CNT_W'(1))
      |=> run && addr == AW'($past(addr) + 1'b1) && remain == $past(remain) - 1'b1);

   // R9: without a handshake, position and count hold even if a start arrives
   p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !fire && !abort_req) |=> $stable(addr) && $stable(remain) && run);

   // R11: a start that moves no words leaves the engine done
   p_zero_len_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && start && !abort_req && (size_bytes >> 2) == '0) |=> done);

endmodule

// File: rtl/cfgbuf_engine.sv
module cfgbuf_engine
   import cfgbuf_pkg::*;
#(
   parameter int WORDS    = 512,
   parameter int DATA_W   = 32,
   localparam int ADDR_W  = $clog2(WORDS * 4) + 1,
   localparam int AW      = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              cp_wr_valid,
   input  logic              cp_wr_ready,
   output logic [DATA_W-1:0] cp_wr_data,
   input  logic              cp_rd_valid,
   output logic              cp_rd_ready,
   input  logic [DATA_W-1:0] cp_rd_data,
   input  logic              cp_abort_n,
   input  logic              cp_rip,
   input  logic              cp_aligned,
   input  logic              cp_cfg_err
);

   generate
      if ((WORDS & (WORDS - 1)) != 0 || WORDS < 4)
         $error("cfgbuf_engine: WORDS must be a power of two of at least 4");
      if (DATA_W < 16)
         $error("cfgbuf_engine: DATA_W must be at least 16");
   endgenerate

   logic              in_regs;
   cfgbuf_reg_e       reg_sel;
   logic [AW-1:0]     word_idx;
   logic              wr_cyc, rd_cyc;
   logic              start, soft_rst;
   logic [DATA_W-1:0] size_q, offset_q, status_w, reg_rd_q, buf_rdata;
   logic              rd_buf_q;
   logic              eng_done, eng_we;
   logic [AW-1:0]     eng_addr;
   logic [DATA_W-1:0] eng_wdata;
   logic [1:0]        unused_lsb;

   assign in_regs    = bus_addr[ADDR_W-1];
   assign reg_sel    = cfgbuf_reg_e'(bus_addr[3:2]);
   assign word_idx   = bus_addr[ADDR_W-2:2];
   assign unused_lsb = bus_addr[1:0];
   assign wr_cyc     = bus_sel && bus_we;
   assign rd_cyc     = bus_sel && !bus_we;
   assign start      = wr_cyc && in_regs && (reg_sel == REG_DIR);
   assign soft_rst   = wr_cyc && in_regs && (reg_sel == REG_STATUS);

   always_comb begin
      status_w = '0;
      status_w[STAT_DONE_BIT]              = eng_done;
      status_w[STAT_ONES_HI:STAT_ONES_LO]  = '1;
      status_w[STAT_PORT_LO]               = cp_abort_n;
      status_w[STAT_PORT_LO + 1]           = cp_rip;
      status_w[STAT_PORT_LO + 2]           = cp_aligned;
      status_w[STAT_PORT_LO + 3]           = cp_cfg_err;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         size_q   <= '0;
         offset_q <= '0;
         rd_buf_q <= 1'b0;
         reg_rd_q <= '0;
      end else begin
         if (wr_cyc && in_regs && reg_sel == REG_SIZE)   size_q   <= bus_wdata;
         if (wr_cyc && in_regs && reg_sel == REG_OFFSET) offset_q <= bus_wdata;
         if (rd_cyc) begin
            rd_buf_q <= !in_regs;
            unique case (reg_sel)
               REG_SIZE:   reg_rd_q <= size_q;
               REG_OFFSET: reg_rd_q <= offset_q;
               REG_DIR:    reg_rd_q <= '0;
               REG_STATUS: reg_rd_q <= status_w;
            endcase
         end
      end
   end

   assign bus_rdata = rd_buf_q ? buf_rdata : reg_rd_q;

   cfgbuf_ram #(.WORDS(WORDS), .DATA_W(DATA_W)) u_ram (
      .clk     (clk),
      .h_we    (wr_cyc && !in_regs),
      .h_addr  (word_idx),
      .h_wdata (bus_wdata),
      .h_rdata (buf_rdata),
      .e_we    (eng_we),
      .e_addr  (eng_addr),
      .e_wdata (eng_wdata),
      .e_rdata (cp_wr_data)
   );

   cfgbuf_seq #(.WORDS(WORDS), .DATA_W(DATA_W)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .start_dir    (bus_wdata[0]),
      .abort_req    (soft_rst),
      .size_bytes   (size_q),
      .offset_words (offset_q),
      .wr_ready     (cp_wr_ready),
      .rd_valid     (cp_rd_valid),
      .rd_data      (cp_rd_data),
      .done         (eng_done),
      .wr_valid     (cp_wr_valid),
      .rd_ready     (cp_rd_ready),
      .mem_addr     (eng_addr),
      .mem_we       (eng_we),
      .mem_wdata    (eng_wdata)
   );

   // R8: a status write leaves the engine idle with both strobes low
   p_soft_reset_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> eng_done && !cp_wr_valid && !cp_rd_ready);

   // R6: every status read shows fixed ones in bits 4:1 and zeros above bit 8
   p_status_fixed_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_cyc && in_regs && reg_sel == REG_STATUS)
      |=> bus_rdata[4:1] == 4'hF && bus_rdata[DATA_W-1:9] == '0);

   // R3: port strobes only while a transfer runs
   p_strobes_only_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_wr_valid || cp_rd_ready) |-> !eng_done && !(cp_wr_valid && cp_rd_ready));

endmodule

// File: tb/cfgbuf_engine_tb.sv
module cfgbuf_engine_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_we = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        cp_wr_valid, cp_wr_ready = 1'b0;
   logic [31:0] cp_wr_data;
   logic        cp_rd_valid = 1'b0, cp_rd_ready;
   logic [31:0] cp_rd_data;
   logic        cp_abort_n = 1'b1, cp_rip = 1'b0, cp_aligned = 1'b0, cp_cfg_err = 1'b0;

   int          n_chk = 0, n_fail = 0;
   bit          all_done = 1'b0;
   int          cap_n = 0, rb_n = 0;
   logic [31:0] cap [0:1023];
   logic [31:0] rb_base = 32'h5000_0000;

   always #2 clk = ~clk;  // 250 MHz

   assign cp_rd_data = rb_base + 32'(rb_n);

   cfgbuf_engine u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cp_wr_valid(cp_wr_valid), .cp_wr_ready(cp_wr_ready), .cp_wr_data(cp_wr_data),
      .cp_rd_valid(cp_rd_valid), .cp_rd_ready(cp_rd_ready), .cp_rd_data(cp_rd_data),
      .cp_abort_n(cp_abort_n), .cp_rip(cp_rip), .cp_aligned(cp_aligned),
      .cp_cfg_err(cp_cfg_err)
   );

   // port models: record configure words and count readback words
   always @(posedge clk) begin
      if (rst_n && cp_wr_valid && cp_wr_ready) begin
         cap[cap_n[9:0]] <= cp_wr_data;
         cap_n <= cap_n + 1;
      end
      if (rst_n && cp_rd_valid && cp_rd_ready)
         rb_n <= rb_n + 1;
   end

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
      @(posedge clk); #1;
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(posedge clk); #1;
      bus_sel = 1'b0;
      d = bus_rdata;
   endtask

   task automatic wait_done(input string tag);
      logic [31:0] s;
      for (int i = 0; i < 3000; i++) begin
         bus_rd(12'h80C, s);
         if (s[0]) return;
      end
      check(tag, 32'h0, 32'h1);
   endtask

   localparam int NVEC = 6;
   // {byte address, write data}; each is written and then read back (R1, R2)
   localparam logic [43:0] VEC [NVEC] = '{
      {12'h000, 32'h1234_5678},
      {12'h004, 32'h9ABC_DEF0},
      {12'h7FC, 32'hCAFE_0511},
      {12'h100, 32'h0F0F_0040},
      {12'h800, 32'h0000_0013},
      {12'h804, 32'h0000_01F7}
   };

   initial begin
      logic [31:0] r;
      int c0, r0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R6: reset status with abort_n high, other flags low
      bus_rd(12'h80C, r);
      check("R6 reset status", r, 32'h0000_003F);

      // R1 / R2: table walk
      for (int i = 0; i < NVEC; i++) bus_wr(VEC[i][43:32], VEC[i][31:0]);
      for (int i = 0; i < NVEC; i++) begin
         bus_rd(VEC[i][43:32], r);
         check(VEC[i][43] ? "R2 register readback" : "R1 buffer readback", r, VEC[i][31:0]);
      end

      // R7: port flags in status bits 5..8
      cp_abort_n = 1'b0; cp_rip = 1'b1; cp_aligned = 1'b0; cp_cfg_err = 1'b1;
      bus_rd(12'h80C, r);
      check("R7 port flags", r, 32'h0000_015F);
      cp_abort_n = 1'b1; cp_rip = 1'b0; cp_cfg_err = 1'b0; cp_aligned = 1'b1;
      bus_rd(12'h80C, r);
      check("R7 aligned flag", r, 32'h0000_00BF);
      cp_aligned = 1'b0;

      // fill buffer words 0..15 with a known pattern
      for (int i = 0; i < 16; i++) bus_wr(12'(i * 4), 32'hA500_0000 | 32'(i));

      // R3 / R4: configure 27 bytes (6 words) from word 3
      c0 = cap_n;
      bus_wr(12'h800, 32'd27);
      bus_wr(12'h804, 32'd3);
      bus_wr(12'h808, 32'd0);
      bus_rd(12'h80C, r);
      check("R3 busy after start", {31'b0, r[0]}, 32'h0);
      check("R3 no handshake while not ready", 32'(cap_n - c0), 32'h0);
      cp_wr_ready = 1'b1;
      wait_done("R4 configure completes");
      check("R4 configure word count", 32'(cap_n - c0), 32'd6);
      for (int k = 0; k < 6; k++)
         check("R4 configure word order", cap[(c0 + k) % 1024], 32'hA500_0000 | 32'(3 + k));
      cp_wr_ready = 1'b0;

      // R9: second start while busy is ignored
      c0 = cap_n;
      bus_wr(12'h800, 32'd8);
      bus_wr(12'h804, 32'd0);
      bus_wr(12'h808, 32'd0);
      bus_wr(12'h800, 32'd40);
      bus_wr(12'h804, 32'd10);
      bus_wr(12'h808, 32'd0);
      cp_wr_ready = 1'b1;
      wait_done("R9 first transfer completes");
      check("R9 word count kept", 32'(cap_n - c0), 32'd2);
      check("R9 first word", cap[c0 % 1024], 32'hA500_0000);
      check("R9 second word", cap[(c0 + 1) % 1024], 32'hA500_0001);
      cp_wr_ready = 1'b0;

      // R5: readback 16 bytes into words 20..23, neighbours untouched
      bus_wr(12'd19 * 4, 32'hBEEF_0019);
      bus_wr(12'd24 * 4, 32'hDEAD_0024);
      cp_rd_valid = 1'b1;
      r0 = rb_n;
      bus_wr(12'h800, 32'd16);
      bus_wr(12'h804, 32'd20);
      bus_wr(12'h808, 32'd1);
      wait_done("R5 readback completes");
      check("R5 readback count", 32'(rb_n - r0), 32'd4);
      for (int k = 0; k < 4; k++) begin
         bus_rd(12'((20 + k) * 4), r);
         check("R5 readback word", r, rb_base + 32'(r0 + k));
      end
      bus_rd(12'd19 * 4, r);
      check("R5 word below untouched", r, 32'hBEEF_0019);
      bus_rd(12'd24 * 4, r);
      check("R5 word above untouched", r, 32'hDEAD_0024);

      // R10: readback from word 510 asking for 4 words clamps to 2
      r0 = rb_n;
      bus_wr(12'h800, 32'd16);
      bus_wr(12'h804, 32'd510);
      bus_wr(12'h808, 32'd1);
      wait_done("R10 clamped transfer completes");
      check("R10 clamped count", 32'(rb_n - r0), 32'd2);
      bus_rd(12'h7FC, r);
      check("R10 last word filled", r, rb_base + 32'(r0 + 1));
      cp_rd_valid = 1'b0;

      // R10: offset beyond the buffer moves nothing and reports done
      c0 = cap_n;
      cp_wr_ready = 1'b1;
      bus_wr(12'h800, 32'd8);
      bus_wr(12'h804, 32'd600);
      bus_wr(12'h808, 32'd0);
      bus_rd(12'h80C, r);
      check("R10 offset past end done", {31'b0, r[0]}, 32'h1);
      check("R10 offset past end no words", 32'(cap_n - c0), 32'h0);

      // R11: fewer than four bytes moves nothing
      bus_wr(12'h800, 32'd3);
      bus_wr(12'h804, 32'd0);
      bus_wr(12'h808, 32'd0);
      bus_rd(12'h80C, r);
      check("R11 zero length done", {31'b0, r[0]}, 32'h1);
      check("R11 zero length no words", 32'(cap_n - c0), 32'h0);
      cp_wr_ready = 1'b0;

      // R8: status write abandons a running transfer
      bus_wr(12'h800, 32'd40);
      bus_wr(12'h804, 32'd0);
      bus_wr(12'h808, 32'd0);
      bus_rd(12'h80C, r);
      check("R8 busy before soft reset", {31'b0, r[0]}, 32'h0);
      bus_wr(12'h80C, 32'h0000_FEFE);
      bus_rd(12'h80C, r);
      check("R8 done after soft reset", r, 32'h0000_003F);
      c0 = cap_n;
      cp_wr_ready = 1'b1;
      repeat (8) @(posedge clk);
      #1;
      check("R8 no words after soft reset", 32'(cap_n - c0), 32'h0);
      cp_wr_ready = 1'b0;

      all_done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!all_done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired got running expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule